// File: doc/BRIEF.md
# Dual Sub-frame Doppler Sequencer

The sequencer collects one radar frame of range samples, 32 chirps deep, into an internal buffer addressed by range bin and chirp number. Once the frame is complete, it processes the frame as two separate halves of 16 chirps each. For every range bin it handles the first half and then the second. For each half it reads the 16 samples in chirp order, multiplies each by a 16-point Hamming coefficient and streams the results to an external 16-point FFT core over a valid/ready handshake.

After the 16th sample is accepted, the block waits for the core to return 16 results. It forwards each result with its range bin and a 5-bit Doppler index. The top bit of that index is the half, and the low 4 bits are the bin within the half. The zero-velocity bin of each half is forced to zero. A single-cycle pulse then marks the end of the frame, and the block goes back to accepting samples.

Within a chirp, samples arrive ordered by range bin. A start-of-frame pulse may arrive at any point while samples are being gathered. It restarts the gathering, including at the boundary between the two halves.

Top module: `doppler_subframe_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `fft_in_valid`, `out_valid`, `frame_full` and `frame_complete` are all low.
- R2: Accepted samples fill range bins 0..RANGE_BINS-1 of chirp 0, then of chirp 1, and so on. `frame_full` pulses for one cycle, one clock after the RANGE_BINS*32-th sample, and never before it.
- R3: `frame_start` high while samples are being gathered discards the partial frame, including at chirp 16. A sample presented in the same cycle becomes range bin 0 of chirp 0.
- R4: From the `frame_full` pulse until `frame_complete`, `in_valid` and `frame_start` have no effect: no further `frame_full` pulse and no change to any output value.
- R5: Each streamed sample s at position n (0..15) of its half is the 16-bit result of (s*c(n) + 16384) >> 15, with an arithmetic shift. The coefficient c(n) is round(32768*(0.54 - 0.46*cos(2*pi*n/15))).
- R6: Each transform receives exactly 16 samples, chirps 16*h to 16*h+15 of one range bin in chirp order. `fft_in_last` is high only on the 16th. While `fft_in_valid` is high and `fft_in_ready` is low, valid and data are held.
- R7: Results leave with range bin as the outer order, half as the middle order and result index as the inner order. `out_rbin` carries the range bin. `out_dbin` equals 16*half + k for the k-th result, and `out_data` equals that result.
- R8: A result whose `out_dbin[3:0]` is zero (index 0 or 16) is output as zero. This applies to each half independently.
- R9: `frame_complete` pulses one cycle after the last result of the last range bin. The block then accepts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Range sample present |
| in_data | input | SAMPLE_W | Signed range sample |
| frame_start | input | 1 | Restart frame gathering |
| frame_full | output | 1 | One-cycle pulse: frame buffer filled |
| fft_in_valid | output | 1 | Windowed sample offered to the FFT |
| fft_in_data | output | SAMPLE_W | Windowed sample |
| fft_in_last | output | 1 | 16th sample of a transform |
| fft_in_ready | input | 1 | FFT accepts the offered sample |
| fft_out_valid | input | 1 | FFT result present |
| fft_out_data | input | SAMPLE_W | FFT result |
| out_valid | output | 1 | Doppler output present |
| out_data | output | SAMPLE_W | Doppler value after the DC notch |
| out_rbin | output | clog2(RANGE_BINS) | Range bin of the output |
| out_dbin | output | 5 | {half, bin within half} |
| frame_complete | output | 1 | One-cycle pulse: frame processed |

## Verification
Two pairs of events can share a cycle. The first pair is a restart pulse and a sample write. The bench raises `frame_start` together with the first sample of chirp 16 of a partial frame. It judges the outcome by the windowed values sent to the FFT and by the exact cycle of the fill pulse, both of which reflect only the new frame.

The second pair is a new sample or restart pulse arriving while a transform is in flight. The bench drives both in the cycles after the fill pulse, under FFT back-pressure. It requires that no extra fill pulse appears and that every Doppler output still matches the model built from the original frame.

// File: rtl/dss_pkg.sv
package dss_pkg;

  localparam int DSS_SUB_LEN = 16;
  localparam int DSS_IDX_W   = 4;
  localparam int DSS_NSUB    = 2;
  localparam int DSS_CHIRPS  = DSS_SUB_LEN * DSS_NSUB;
  localparam int DSS_COEF_W  = 16;

  typedef enum logic [2:0] {
    DSS_IDLE = 3'b000,
    DSS_PRE  = 3'b001,
    DSS_LOAD = 3'b010,
    DSS_WAIT = 3'b011,
    DSS_OUT  = 3'b100
  } dss_state_e;

  // Symmetric 16-point Hamming taps in Q15; taps 8..15 mirror taps 7..0.
  function automatic logic [DSS_COEF_W-1:0] dss_hamming(input logic [DSS_IDX_W-1:0] n);
    logic [DSS_IDX_W-2:0] h;
    h = n[DSS_IDX_W-1] ? ~n[DSS_IDX_W-2:0] : n[DSS_IDX_W-2:0];
    case (h)
      3'd0:    return 16'd2621;
      3'd1:    return 16'd3925;
      3'd2:    return 16'd7609;
      3'd3:    return 16'd13037;
      3'd4:    return 16'd19270;
      3'd5:    return 16'd25231;
      3'd6:    return 16'd29889;
      default: return 16'd32439;
    endcase
  endfunction

  // Zero-velocity test on the bin index within one half.
  function automatic logic dss_is_dc(input logic [DSS_IDX_W:0] bin);
    return bin[DSS_IDX_W-1:0] == '0;
  endfunction

endpackage

// File: rtl/dss_window.sv
module dss_window
  import dss_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]         smp,
  input  logic [DSS_IDX_W-1:0] pos,
  output logic [W-1:0]         y
);

  localparam int PW   = W + DSS_COEF_W + 1;
  localparam int FRAC = DSS_COEF_W - 1;
  localparam logic signed [PW-1:0] HALF = PW'(1) << (FRAC - 1);

  function automatic logic [W-1:0] apply_tap(input logic [W-1:0] s, input logic [DSS_COEF_W-1:0] c);
    logic signed [W-1:0]          a;
    logic signed [DSS_COEF_W:0]   b;
    logic signed [PW-1:0]         p;
    a = s;
    b = {1'b0, c};
    p = PW'(a) * PW'(b);
    p = p + HALF;
    return p[W+FRAC-1:FRAC];
  endfunction

  assign y = apply_tap(smp, dss_hamming(pos));

endmodule

// File: rtl/dss_frame_buf.sv
module dss_frame_buf
  import dss_pkg::*;
#(
  parameter int W          = 16,
  parameter int RANGE_BINS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_restart,
  input  logic [W-1:0]  wr_data,
  output logic          full,
  input  logic          rd_en,
  input  logic [$clog2(RANGE_BINS)+DSS_IDX_W:0] rd_addr,
  output logic [W-1:0]  rd_data
);

  localparam int RB_W  = $clog2(RANGE_BINS);
  localparam int CH_W  = DSS_IDX_W + 1;
  localparam int AW    = RB_W + CH_W;
  localparam int DEPTH = RANGE_BINS * DSS_CHIRPS;

  logic [W-1:0]    mem [DEPTH];
  logic [RB_W-1:0] wr_rb, rb_cur;
  logic [CH_W-1:0] wr_ch, ch_cur;
  logic [AW-1:0]   wr_addr;
  logic            rb_wrap, ch_wrap;

  always_comb begin
    rb_cur  = wr_restart ? '0 : wr_rb;
    ch_cur  = wr_restart ? '0 : wr_ch;
    rb_wrap = rb_cur == RB_W'(RANGE_BINS - 1);
    ch_wrap = ch_cur == CH_W'(DSS_CHIRPS - 1);
    wr_addr = {rb_cur, ch_cur};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_rb <= '0;
      wr_ch <= '0;
      full  <= 1'b0;
    end else begin
      full <= 1'b0;
      if (wr_en) begin
        if (rb_wrap) begin
          wr_rb <= '0;
          wr_ch <= ch_wrap ? '0 : ch_cur + CH_W'(1);
          full  <= ch_wrap;
        end else begin
          wr_rb <= rb_cur + RB_W'(1);
          wr_ch <= ch_cur;
        end
      end else if (wr_restart) begin
        wr_rb <= '0;
        wr_ch <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

  p_rd_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> int'(rd_addr) < DEPTH);

endmodule

// File: rtl/dss_ctrl.sv
module dss_ctrl
  import dss_pkg::*;
#(
  parameter int W          = 16,
  parameter int RANGE_BINS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  frame_start,
  input  logic                  frame_full,
  output logic                  wr_en,
  output logic                  wr_restart,
  output logic                  rd_en,
  output logic [$clog2(RANGE_BINS)+DSS_IDX_W:0] rd_addr,
  output logic [DSS_IDX_W-1:0]  win_idx,
  output logic                  fft_in_valid,
  output logic                  fft_in_last,
  input  logic                  fft_in_ready,
  input  logic                  fft_out_valid,
  input  logic [W-1:0]          fft_out_data,
  output logic                  out_valid,
  output logic [W-1:0]          out_data,
  output logic [$clog2(RANGE_BINS)-1:0] out_rbin,
  output logic [DSS_IDX_W:0]    out_dbin,
  output logic                  frame_complete
);

  localparam int RB_W = $clog2(RANGE_BINS);

  dss_state_e           st;
  logic [RB_W-1:0]      rb;
  logic                 sub;
  logic [DSS_IDX_W-1:0] idx, idx_nxt, k;

  // named internal events
  logic gathering, load_hs, load_end, res_take, res_end, last_rb, dc_hit;

  assign gathering  = (st == DSS_IDLE) && !frame_full;
  assign load_hs    = (st == DSS_LOAD) && fft_in_ready;
  assign load_end   = load_hs && (idx == DSS_IDX_W'(DSS_SUB_LEN - 1));
  assign res_take   = (st == DSS_WAIT) && fft_out_valid;
  assign res_end    = res_take && (k == DSS_IDX_W'(DSS_SUB_LEN - 1));
  assign last_rb    = rb == RB_W'(RANGE_BINS - 1);
  assign dc_hit     = dss_is_dc({sub, k});

  assign idx_nxt      = load_hs ? idx + DSS_IDX_W'(1) : idx;
  assign wr_en        = in_valid && gathering;
  assign wr_restart   = frame_start && gathering;
  assign rd_en        = (st == DSS_PRE) || (st == DSS_LOAD);
  assign rd_addr      = {rb, sub, idx_nxt};
  assign win_idx      = idx;
  assign fft_in_valid = st == DSS_LOAD;
  assign fft_in_last  = fft_in_valid && (idx == DSS_IDX_W'(DSS_SUB_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st             <= DSS_IDLE;
      rb             <= '0;
      sub            <= 1'b0;
      idx            <= '0;
      k              <= '0;
      out_valid      <= 1'b0;
      out_data       <= '0;
      out_rbin       <= '0;
      out_dbin       <= '0;
      frame_complete <= 1'b0;
    end else begin
      out_valid      <= 1'b0;
      frame_complete <= 1'b0;
      case (st)
        DSS_IDLE: if (frame_full) st <= DSS_PRE;
        DSS_PRE:  st <= DSS_LOAD;
        DSS_LOAD: begin
          idx <= idx_nxt;
          if (load_end) st <= DSS_WAIT;
        end
        DSS_WAIT: if (res_take) begin
          out_valid <= 1'b1;
          out_data  <= dc_hit ? '0 : fft_out_data;
          out_rbin  <= rb;
          out_dbin  <= {sub, k};
          k         <= k + DSS_IDX_W'(1);
          if (res_end) st <= DSS_OUT;
        end
        DSS_OUT: begin
          if (sub) begin
            sub <= 1'b0;
            if (last_rb) begin
              rb             <= '0;
              frame_complete <= 1'b1;
              st             <= DSS_IDLE;
            end else begin
              rb <= rb + RB_W'(1);
              st <= DSS_PRE;
            end
          end else begin
            sub <= 1'b1;
            st  <= DSS_PRE;
          end
        end
        default: st <= DSS_IDLE;
      endcase
    end
  end

  p_full_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_full |=> st == DSS_PRE);

  p_dc_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_dbin[DSS_IDX_W-1:0] == '0) |-> out_data == '0);

  p_complete_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_complete |-> ($past(out_valid) && $past(out_dbin) == '1
                        && $past(out_rbin) == RB_W'(RANGE_BINS - 1)));

  p_no_full_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st != DSS_IDLE) |-> !frame_full);

endmodule

// File: rtl/doppler_subframe_seq.sv
module doppler_subframe_seq
  import dss_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int RANGE_BINS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [SAMPLE_W-1:0]           in_data,
  input  logic                          frame_start,
  output logic                          frame_full,
  output logic                          fft_in_valid,
  output logic [SAMPLE_W-1:0]           fft_in_data,
  output logic                          fft_in_last,
  input  logic                          fft_in_ready,
  input  logic                          fft_out_valid,
  input  logic [SAMPLE_W-1:0]           fft_out_data,
  output logic                          out_valid,
  output logic [SAMPLE_W-1:0]           out_data,
  output logic [$clog2(RANGE_BINS)-1:0] out_rbin,
  output logic [DSS_IDX_W:0]            out_dbin,
  output logic                          frame_complete
);

  localparam int AW = $clog2(RANGE_BINS) + DSS_IDX_W + 1;

  logic                 wr_en, wr_restart, rd_en;
  logic [AW-1:0]        rd_addr;
  logic [SAMPLE_W-1:0]  rd_data;
  logic [DSS_IDX_W-1:0] win_idx;

  dss_frame_buf #(.W(SAMPLE_W), .RANGE_BINS(RANGE_BINS)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_restart (wr_restart),
    .wr_data    (in_data),
    .full       (frame_full),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data)
  );

  dss_ctrl #(.W(SAMPLE_W), .RANGE_BINS(RANGE_BINS)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .frame_start    (frame_start),
    .frame_full     (frame_full),
    .wr_en          (wr_en),
    .wr_restart     (wr_restart),
    .rd_en          (rd_en),
    .rd_addr        (rd_addr),
    .win_idx        (win_idx),
    .fft_in_valid   (fft_in_valid),
    .fft_in_last    (fft_in_last),
    .fft_in_ready   (fft_in_ready),
    .fft_out_valid  (fft_out_valid),
    .fft_out_data   (fft_out_data),
    .out_valid      (out_valid),
    .out_data       (out_data),
    .out_rbin       (out_rbin),
    .out_dbin       (out_dbin),
    .frame_complete (frame_complete)
  );

  dss_window #(.W(SAMPLE_W)) u_win (
    .smp (rd_data),
    .pos (win_idx),
    .y   (fft_in_data)
  );

  p_offer_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fft_in_valid && !fft_in_ready) |=> (fft_in_valid && $stable(fft_in_data)));

endmodule

// File: tb/doppler_subframe_seq_bench.sv
module doppler_subframe_seq_bench;

  localparam int W   = 16;
  localparam int RB  = 4;
  localparam int NCH = 32;
  localparam int SL  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid, frame_start, fft_in_ready, fft_out_valid;
  logic [W-1:0] in_data, fft_out_data;
  logic frame_full, fft_in_valid, fft_in_last, out_valid, frame_complete;
  logic [W-1:0] fft_in_data, out_data;
  logic [1:0] out_rbin;
  logic [4:0] out_dbin;

  always #2 clk = ~clk;

  doppler_subframe_seq #(.SAMPLE_W(W), .RANGE_BINS(RB)) u_doppler_subframe_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .frame_start(frame_start), .frame_full(frame_full),
    .fft_in_valid(fft_in_valid), .fft_in_data(fft_in_data), .fft_in_last(fft_in_last),
    .fft_in_ready(fft_in_ready), .fft_out_valid(fft_out_valid), .fft_out_data(fft_out_data),
    .out_valid(out_valid), .out_data(out_data), .out_rbin(out_rbin), .out_dbin(out_dbin),
    .frame_complete(frame_complete)
  );

  int checks = 0, fails = 0;
  int fr [RB][NCH];
  int coef [SL];
  int q_rb[$], q_db[$], q_dat[$];
  bit bp = 1'b0;
  int cyc = 0, delivered = 0;
  int m_i = 0, m_sub = 0, m_rb = 0;
  int cap [SL];
  bit ret_on = 1'b0;
  int ret_delay = 0, rk = 0, ret_rb = 0, ret_sub = 0;

  function automatic int sx(input logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  function automatic int win_ref(input int s, input int n);
    int p;
    p = s * coef[n] + 16384;
    return sx(16'(p >>> 15));
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference model and FFT stub, evaluated every clock at the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (out_valid) begin
        if (q_rb.size() == 0) chk(1'b0, "R7", "unexpected output", int'(out_dbin), -1);
        else begin
          int erb, edb, edat;
          erb = q_rb.pop_front(); edb = q_db.pop_front(); edat = q_dat.pop_front();
          chk(int'(out_rbin) == erb, "R7", "range bin", int'(out_rbin), erb);
          chk(int'(out_dbin) == edb, "R7", "doppler bin", int'(out_dbin), edb);
          chk(sx(out_data) == edat, (edb % SL == 0) ? "R8" : "R7", "value", sx(out_data), edat);
          delivered++;
        end
      end
      if (frame_complete) begin
        chk(delivered == RB*NCH && q_rb.size() == 0, "R9", "outputs before completion", delivered, RB*NCH);
        delivered = 0;
      end
      fft_in_ready = bp ? (cyc % 3 != 2) : 1'b1;
      if (fft_in_valid && fft_in_ready) begin
        int e;
        e = win_ref(fr[m_rb][m_sub*SL + m_i], m_i);
        chk(sx(fft_in_data) == e, "R5", "windowed sample", sx(fft_in_data), e);
        chk(fft_in_last == (m_i == SL-1), "R6", "last flag", int'(fft_in_last), int'(m_i == SL-1));
        cap[m_i] = sx(fft_in_data);
        if (m_i == SL-1) begin
          ret_on = 1'b1; ret_delay = 3; rk = 0; ret_rb = m_rb; ret_sub = m_sub; m_i = 0;
          if (m_sub == 1) begin m_sub = 0; m_rb = (m_rb + 1) % RB; end
          else m_sub = 1;
        end else m_i++;
      end
      fft_out_valid = 1'b0;
      if (ret_on) begin
        if (ret_delay > 0) ret_delay--;
        else if (!bp || cyc % 2 == 0) begin
          logic [W-1:0] v;
          v = 16'(cap[rk] + 100);
          fft_out_valid = 1'b1;
          fft_out_data = v;
          q_rb.push_back(ret_rb);
          q_db.push_back(ret_sub*SL + rk);
          q_dat.push_back(rk == 0 ? 0 : sx(v));
          rk++;
          if (rk == SL) ret_on = 1'b0;
        end
      end
    end
  end

  function automatic logic [W-1:0] pat(input int r, input int c, input int seed);
    if (seed == 3) return ((r + c) % 2 == 1) ? 16'h7fff : 16'h8000;
    return 16'((r*4099 + c*613 + seed*9173) % 65536);
  endfunction

  task automatic send_frame(input int seed, input string tag);
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < RB; r++) begin
        @(negedge clk);
        in_valid = 1'b1; in_data = pat(r, c, seed); frame_start = (c == 0 && r == 0);
        fr[r][c] = sx(in_data);
        chk(frame_full == 1'b0, tag, "fill pulse too early", int'(frame_full), 0);
      end
    @(negedge clk);
    in_valid = 1'b0; frame_start = 1'b0;
    chk(frame_full == 1'b1, tag, "fill pulse after last sample", int'(frame_full), 1);
  endtask

  task automatic wait_done();
    while (!frame_complete) @(negedge clk);
  endtask

  initial begin
    for (int n = 0; n < SL; n++)
      coef[n] = $rtoi(32768.0 * (0.54 - 0.46 * $cos(2.0 * 3.14159265358979 * n / 15.0)) + 0.5);
    in_valid = 1'b0; in_data = '0; frame_start = 1'b0;
    fft_in_ready = 1'b1; fft_out_valid = 1'b0; fft_out_data = '0;
    repeat (3) @(negedge clk);
    chk(!out_valid && !fft_in_valid && !frame_full && !frame_complete, "R1", "outputs in reset",
        int'({out_valid, fft_in_valid, frame_full, frame_complete}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !fft_in_valid && !frame_full && !frame_complete, "R1", "outputs after reset",
        int'({out_valid, fft_in_valid, frame_full, frame_complete}), 0);

    // Frame A: free-flowing FFT
    send_frame(1, "R2");
    wait_done();

    // Frame B: 16 junk chirps, restart at the half boundary, back-pressure
    bp = 1'b1;
    for (int c = 0; c < SL; c++)
      for (int r = 0; r < RB; r++) begin
        @(negedge clk);
        in_valid = 1'b1; in_data = 16'(c*77 + r); frame_start = (c == 0 && r == 0);
        chk(frame_full == 1'b0, "R3", "fill pulse on partial frame", int'(frame_full), 0);
      end
    send_frame(2, "R3");
    begin
      int f0;
      f0 = fails;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        in_valid = 1'b1; in_data = 16'(16'h5a5a ^ i); frame_start = (i % 4 == 0);
        chk(frame_full == 1'b0, "R4", "fill pulse while busy", int'(frame_full), 0);
      end
      @(negedge clk);
      in_valid = 1'b0; frame_start = 1'b0;
      wait_done();
      chk(fails == f0, "R4", "outputs disturbed by busy-time input", fails - f0, 0);
    end

    // Frame C: full-scale extremes, back-pressure kept, accepted after completion
    send_frame(3, "R9");
    wait_done();
    repeat (3) @(negedge clk);
    chk(q_rb.size() == 0 && !fft_in_valid, "R9", "idle after frame", q_rb.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R9: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule